// File: doc/BRIEF.md
# Temperature Result Holding Register

This block keeps the last finished temperature reading in a 16-bit, read-only result word that a host may read at any moment. A conversion engine delivers a signed raw sample and a one-cycle completion strobe. The block left-justifies that sample into the 16-bit word and clears every bit below the resolution the host selected, so the word carries 9, 10, 11 or 12 significant bits.

While the host has a read cycle open, the visible word is frozen so that the bytes being shifted out belong to one sample. A conversion that completes during that time does not reach the visible word, and that update is lost. The next conversion that completes with no read open is the one the host sees. Every completed conversion, frozen or not, is copied at once into a comparator buffer for the alarm logic. A one-cycle pulse marks each new buffer value.

Top module: `temp_result_reg`

## Requirements
- R1: The result word is 16-bit two's complement. Raw sample bit 11 (the sign) lands in word bit 15, raw bit 10 (the temperature MSB) lands in bit 14, and each lower raw bit follows in order down to word bit 4.
- R2: Resolution select code 0 keeps word bits 15..7 (9 bits), code 1 keeps 15..6 (10 bits), code 2 keeps 15..5 (11 bits) and code 3 keeps 15..4 (12 bits). Every other bit of the stored value is zero.
- R3: Word bits 3..0 of both the result word and the comparator buffer are always zero.
- R4: On a clock edge where `conv_done` is 1 and `rd_active` is 0, the masked sample is visible on `result_q` after that edge.
- R5: On a clock edge where `conv_done` and `rd_active` are both 1, `result_q` keeps its old value. The dropped sample does not appear later, even after the read ends.
- R6: After a dropped update, the next conversion that completes with `rd_active` at 0 updates `result_q`.
- R7: `cmp_value` loads the masked sample after every edge where `conv_done` is 1, whatever the value of `rd_active`.
- R8: While `rst_n` is 0, `result_q` and `cmp_value` are zero and `cmp_valid` is 0.
- R9: `cmp_valid` is 1 for exactly the one cycle after each edge where `conv_done` is 1, and 0 otherwise.
- R10: When `conv_done` is 0, changes on `rd_active`, `res_sel` or `sample_in` leave `result_q` and `cmp_value` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a conversion has finished |
| sample_in | input | 12 | Raw signed sample at full resolution |
| res_sel | input | 2 | Resolution select, 0 to 3 for 9 to 12 bits |
| rd_active | input | 1 | A host read of the result word is in progress |
| result_q | output | 16 | Host-visible result word |
| cmp_value | output | 16 | Comparator buffer value |
| cmp_valid | output | 1 | One-cycle pulse: new comparator buffer value |

## Verification
The bench drives the same sample at two resolutions, so a mask that is off by one bit position, or that is indexed in reverse order, gives a wrong low bit. It opens reads across a conversion and then closes them with no conversion following. A design that queued the dropped sample would then show it, and a design that did not gate on the read would update at once. It also checks that the comparator buffer keeps tracking while the result word is frozen, which exposes a design that gated both paths. Finally it changes the select and read inputs while no conversion arrives, which catches an output that follows its inputs without waiting for a strobe.

// File: rtl/temp_res_pkg.sv
package temp_res_pkg;
   typedef enum logic [1:0] {
      RES_9  = 2'd0,
      RES_10 = 2'd1,
      RES_11 = 2'd2,
      RES_12 = 2'd3
   } res_code_t;

   // number of kept word bits for a given select code and minimum width
   function automatic int kept_bits(input int min_res, input int code);
      return min_res + code;
   endfunction
endpackage

// File: rtl/temp_res_mask.sv
module temp_res_mask #(
   parameter int WORD_W  = 16,
   parameter int RAW_W   = 12,
   parameter int MIN_RES = 9,
   parameter int CODE_W  = 2
) (
   input  logic [RAW_W-1:0]  raw,
   input  logic [CODE_W-1:0] code,
   output logic [WORD_W-1:0] word
);
   localparam int PAD = WORD_W - RAW_W;
   localparam int KW  = $clog2(WORD_W + 1) + 1;

   logic [KW-1:0] keep;
   assign keep = KW'(MIN_RES) + KW'(code);

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (i < PAD) begin : g_pad
         assign word[i] = 1'b0;
      end else begin : g_data
         assign word[i] = (KW'(WORD_W - i) <= keep) ? raw[i - PAD] : 1'b0;
      end
   end
endmodule

// File: rtl/temp_cmp_stage.sv
module temp_cmp_stage #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q,
   output logic              fresh
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= '0;
         fresh <= 1'b0;
      end else begin
         fresh <= load;
         if (load) q <= d;
      end
   end
endmodule

// File: rtl/temp_hold_stage.sv
module temp_hold_stage #(
   parameter int WORD_W       = 16,
   parameter bit HOLD_ON_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              busy,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q
);
   logic take;

   if (HOLD_ON_READ) begin : g_gated
      assign take = load & ~busy;
   end else begin : g_free
      logic unused_busy;
      assign unused_busy = busy;
      assign take = load;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (take) q <= d;
   end
endmodule

// File: rtl/temp_result_reg.sv
module temp_result_reg #(
   parameter int WORD_W       = 16,
   parameter int MIN_RES      = 9,
   parameter int CODE_W       = 2,
   parameter int RAW_W        = MIN_RES + (1 << CODE_W) - 1,
   parameter bit HOLD_ON_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [RAW_W-1:0]  sample_in,
   input  logic [CODE_W-1:0] res_sel,
   input  logic              rd_active,
   output logic [WORD_W-1:0] result_q,
   output logic [WORD_W-1:0] cmp_value,
   output logic              cmp_valid
);
   localparam int MAX_RES = temp_res_pkg::kept_bits(MIN_RES, (1 << CODE_W) - 1);

   initial begin : param_chk
      assert (RAW_W <= WORD_W) else $error("raw sample wider than word");
      assert (MAX_RES <= RAW_W) else $error("resolution exceeds raw width");
      assert (MIN_RES >= 2) else $error("minimum resolution too small");
   end

   logic [WORD_W-1:0] masked;

   temp_res_mask #(
      .WORD_W(WORD_W), .RAW_W(RAW_W), .MIN_RES(MIN_RES), .CODE_W(CODE_W)
   ) u_mask (
      .raw(sample_in), .code(res_sel), .word(masked)
   );

   temp_cmp_stage #(.WORD_W(WORD_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .load(conv_done), .d(masked),
      .q(cmp_value), .fresh(cmp_valid)
   );

   temp_hold_stage #(.WORD_W(WORD_W), .HOLD_ON_READ(HOLD_ON_READ)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(conv_done), .busy(rd_active),
      .d(masked), .q(result_q)
   );
endmodule

// File: rtl/temp_result_reg_chk.sv
module temp_result_reg_chk #(
   parameter int WORD_W  = 16,
   parameter int MIN_RES = 9,
   parameter int CODE_W  = 2,
   parameter int RAW_W   = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_done,
   input logic [CODE_W-1:0] res_sel,
   input logic              rd_active,
   input logic [WORD_W-1:0] result_q,
   input logic [WORD_W-1:0] cmp_value,
   input logic              cmp_valid
);
   localparam int PAD = WORD_W - RAW_W;
   localparam logic [WORD_W-1:0] ONES = '1;

   p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (result_q[PAD-1:0] == '0) && (cmp_value[PAD-1:0] == '0));

   p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> ((cmp_value & (ONES >> (MIN_RES + int'($past(res_sel))))) == '0));

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !rd_active) |=> (result_q == cmp_value));

   p_hold_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && rd_active) |=> $stable(result_q));

   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> cmp_valid);

   p_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |=> !cmp_valid);

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |=> ($stable(result_q) && $stable(cmp_value)));
endmodule

bind temp_result_reg temp_result_reg_chk #(
   .WORD_W(WORD_W), .MIN_RES(MIN_RES), .CODE_W(CODE_W), .RAW_W(RAW_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .res_sel(res_sel),
   .rd_active(rd_active), .result_q(result_q), .cmp_value(cmp_value),
   .cmp_valid(cmp_valid)
);

// File: tb/temp_result_reg_test.sv
module temp_result_reg_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_done = 1'b0;
   logic [11:0] sample_in = '0;
   logic [1:0]  res_sel = '0;
   logic        rd_active = 1'b0;
   logic [15:0] result_q, cmp_value;
   logic        cmp_valid;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5ns clk = ~clk;

   temp_result_reg uut (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .sample_in(sample_in),
      .res_sel(res_sel), .rd_active(rd_active), .result_q(result_q),
      .cmp_value(cmp_value), .cmp_valid(cmp_valid)
   );

   // {rd, res, sample, expected cmp_value, expected result_q}
   localparam int NV = 10;
   localparam logic [46:0] VEC [NV] = '{
      {1'b0, 2'd0, 12'h7FF, 16'h7F80, 16'h7F80},
      {1'b0, 2'd3, 12'h7FF, 16'h7FF0, 16'h7FF0},
      {1'b1, 2'd1, 12'hFFF, 16'hFFC0, 16'h7FF0},
      {1'b0, 2'd2, 12'hFFF, 16'hFFE0, 16'hFFE0},
      {1'b0, 2'd3, 12'h935, 16'h9350, 16'h9350},
      {1'b1, 2'd0, 12'h935, 16'h9300, 16'h9350},
      {1'b1, 2'd1, 12'h556, 16'h5540, 16'h9350},
      {1'b0, 2'd2, 12'h556, 16'h5560, 16'h5560},
      {1'b0, 2'd0, 12'h801, 16'h8000, 16'h8000},
      {1'b0, 2'd3, 12'h801, 16'h8010, 16'h8010}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one conversion strobe; outputs sampled at the negedge after the loading edge
   task automatic convert(input logic rd, input logic [1:0] res, input logic [11:0] smp);
      @(negedge clk);
      conv_done = 1'b1; rd_active = rd; res_sel = res; sample_in = smp;
      @(negedge clk);
      chk("R9 cmp_valid pulse", 16'(cmp_valid), 16'h1);
      conv_done = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset result_q", result_q, 16'h0000);
      chk("R8 reset cmp_value", cmp_value, 16'h0000);
      chk("R8 reset cmp_valid", 16'(cmp_valid), 16'h0);
      rst_n = 1'b1;

      // R1 R2 R4 R5 R6 R7 via table
      for (int i = 0; i < NV; i++) begin
         convert(VEC[i][46], VEC[i][45:44], VEC[i][43:32]);
         chk($sformatf("R2 R7 cmp_value vec%0d", i), cmp_value, VEC[i][31:16]);
         chk($sformatf("R4 R5 R6 result_q vec%0d", i), result_q, VEC[i][15:0]);
         rd_active = 1'b0;
         @(negedge clk);
         chk("R9 cmp_valid drops", 16'(cmp_valid), 16'h0);
      end

      // R10: churn inputs with no strobe
      rd_active = 1'b1; res_sel = 2'd0; sample_in = 12'h123;
      repeat (2) @(negedge clk);
      rd_active = 1'b0; res_sel = 2'd1; sample_in = 12'hABC;
      repeat (2) @(negedge clk);
      chk("R10 result_q idle", result_q, 16'h8010);
      chk("R10 cmp_value idle", cmp_value, 16'h8010);
      chk("R10 no pulse", 16'(cmp_valid), 16'h0);

      // R5: dropped sample must not appear after read ends
      convert(1'b1, 2'd3, 12'h3C3);
      chk("R7 cmp during read", cmp_value, 16'h3C30);
      chk("R5 frozen during read", result_q, 16'h8010);
      rd_active = 1'b0;
      repeat (3) @(negedge clk);
      chk("R5 dropped stays dropped", result_q, 16'h8010);

      // R6: next unmasked conversion lands; R1 sign/MSB placement
      convert(1'b0, 2'd3, 12'hC00);
      chk("R1 R6 result after drop", result_q, 16'hC000);

      // R3 low nibble zero at finest resolution with all ones
      convert(1'b0, 2'd3, 12'hFFF);
      chk("R3 low bits zero", result_q, 16'hFFF0);

      // R8 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 mid reset result_q", result_q, 16'h0000);
      chk("R8 mid reset cmp_value", cmp_value, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(5ns * 200000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule